// File: doc/BRIEF.md
# Packed halving fractional adder unit

This execution-unit slice adds two signed Q15 halfword lanes packed in each of two 32-bit source operands. Each pair of lanes is summed at 17 bits, so the sum can never saturate, and is then halved by a one-bit arithmetic right shift. An opcode-selected variant adds one to the 17-bit sum before the shift, which rounds halves upward. The two 16-bit lane results are packed into a 64-bit destination value whose upper 32 bits copy the sign of the upper lane result.

The slice decodes the instruction word itself. An input selects one of two encoding tables: a standard 32-bit layout or a compact layout. A word that matches no entry of the selected table is reported as reserved. A word that matches while the DSP-enable input is low is reported as DSP-disabled. In both of those cases no arithmetic result is produced. Operands enter through a valid/ready handshake. A single output register stage presents the result, the decoded destination index and the two flags in the cycle after acceptance.

Top module: `hadd_unit`

## Requirements
- R1: Truncating variant: each 16-bit lane result is bits 16:1 of the 17-bit sum of the two sign-extended lanes (floor of the sum divided by two). For example, 0x7FFF+0x7FFF gives 0x7FFF, 0x8000+0x8000 gives 0x8000 and 0xFFFF+0x0000 gives 0xFFFF.
- R2: Rounding variant: each lane result is bits 16:1 of the 17-bit sum plus one. For example, 0x7FFF+0x7FFF gives 0x7FFF, 0x8000+0x8000 gives 0x8000 and 0xFFFF+0x0000 gives 0x0000.
- R3: The upper lane is taken from operand bits 31:16 and the lower lane from bits 15:0. The 64-bit result is {32 copies of upper-result bit 15, upper result, lower result}.
- R4: With in_compact=0, a word is recognised when bits 31:26=011111 and bits 5:0=011000. Bits 10:6 select the variant: 01000 is truncating and 01010 is rounding. The destination index is bits 15:11, the first source is bits 25:21 and the second source is bits 20:16.
- R5: With in_compact=1, a word is recognised when bits 31:26=000000. Bits 10:0 select the variant: 00001001101 is truncating and 10001001101 is rounding. The destination index is bits 15:11. A word from the standard table is not recognised in this mode, and a compact word is not recognised when in_compact=0.
- R6: An unrecognised word gives out_reserved=1, out_dsp_off=0, out_result=0 and out_dst=0, whatever the level of dsp_en.
- R7: A recognised word while dsp_en=0 gives out_dsp_off=1, out_reserved=0 and out_result=0. A recognised word while dsp_en=1 gives both flags 0 and the arithmetic result.
- R8: in_ready equals (not out_valid) or out_ready. A word accepted at a clock edge appears at that same edge on out_valid, out_result, out_dst and the flags. While out_valid=1 and out_ready=0, all outputs hold their values.
- R9: After reset, out_valid=0 and in_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands offered |
| in_ready | output | 1 | Slice can accept this cycle |
| in_insn | input | 32 | Instruction word |
| in_compact | input | 1 | 1 selects the compact encoding table |
| dsp_en | input | 1 | DSP feature enable |
| src_a | input | 32 | First source operand (two lanes) |
| src_b | input | 32 | Second source operand (two lanes) |
| out_valid | output | 1 | Result register holds an entry |
| out_ready | input | 1 | Consumer takes the entry |
| out_result | output | 64 | Packed, sign-extended result |
| out_dst | output | 5 | Decoded destination register index |
| out_reserved | output | 1 | Word not recognised |
| out_dsp_off | output | 1 | Recognised word with DSP disabled |

## Verification
A wrong carry or rounding input in a lane shows up at the ports in the first accepted word whose sum is odd or crosses a sign boundary, one cycle after acceptance. The sweep covers every pairing of boundary and interior lane values, so such a fault cannot stay hidden. A decode fault shows as a wrong flag or a non-zero result on the very next output. The stalled-consumer test exposes a register stage that fails to hold while the consumer is stalled, or one that admits a second word.

// File: rtl/hadd_pkg.sv
package hadd_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANE_W = 16;
  localparam int unsigned LANES  = WORD_W / LANE_W;
  localparam int unsigned DST_W  = 64;
  localparam int unsigned IDX_W  = 5;

  localparam logic [5:0]  STD_MAJOR   = 6'b011111;
  localparam logic [5:0]  STD_FUNC    = 6'b011000;
  localparam logic [4:0]  STD_TRUNC   = 5'b01000;
  localparam logic [4:0]  STD_ROUND   = 5'b01010;
  localparam logic [5:0]  CMP_MAJOR   = 6'b000000;
  localparam logic [10:0] CMP_TRUNC   = 11'b00001001101;
  localparam logic [10:0] CMP_ROUND   = 11'b10001001101;

  typedef struct packed {
    logic             hit;
    logic             rnd;
    logic [IDX_W-1:0] dst;
  } dec_t;
endpackage

// File: rtl/hadd_decode.sv
module hadd_decode
  import hadd_pkg::*;
(
  input  logic [WORD_W-1:0] insn,
  input  logic              compact,
  output dec_t              dec
);
  logic std_hit, std_rnd, cmp_hit, cmp_rnd;
  logic unused_fields;

  always_comb begin
    std_hit = 1'b0;
    std_rnd = 1'b0;
    if (insn[31:26] == STD_MAJOR && insn[5:0] == STD_FUNC) begin
      if (insn[10:6] == STD_TRUNC) begin
        std_hit = 1'b1;
      end else if (insn[10:6] == STD_ROUND) begin
        std_hit = 1'b1;
        std_rnd = 1'b1;
      end
    end
  end

  always_comb begin
    cmp_hit = 1'b0;
    cmp_rnd = 1'b0;
    if (insn[31:26] == CMP_MAJOR) begin
      if (insn[10:0] == CMP_TRUNC) begin
        cmp_hit = 1'b1;
      end else if (insn[10:0] == CMP_ROUND) begin
        cmp_hit = 1'b1;
        cmp_rnd = 1'b1;
      end
    end
  end

  // Source index fields (25:16) are not needed by this slice.
  assign unused_fields = ^insn[25:16];

  always_comb begin
    dec.hit = compact ? cmp_hit : std_hit;
    dec.rnd = compact ? cmp_rnd : std_rnd;
    dec.dst = dec.hit ? insn[15:11] : '0;
  end
endmodule

// File: rtl/hadd_lane.sv
module hadd_lane #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         rnd,
  output logic [W-1:0] y
);
  logic [W:0] sum;

  always_comb begin
    sum = {a[W-1], a} + {b[W-1], b} + {{W{1'b0}}, rnd};
    y   = sum[W:1];
  end

  always_comb begin
    // R1: trunc result is the floor half, so it lies between the inputs
    if (!rnd) begin
      assert (($signed(y) >= $signed(a) || $signed(y) >= $signed(b)) &&
              ($signed(y) <= $signed(a) || $signed(y) <= $signed(b)))
        else $error("p_trunc_between_r1");
    end
  end
endmodule

// File: rtl/hadd_outreg.sv
module hadd_outreg
  import hadd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             drain,
  input  logic [DST_W-1:0] d_result,
  input  logic [IDX_W-1:0] d_dst,
  input  logic             d_rsv,
  input  logic             d_off,
  output logic             q_valid,
  output logic [DST_W-1:0] q_result,
  output logic [IDX_W-1:0] q_dst,
  output logic             q_rsv,
  output logic             q_off
);
  logic             valid_nx;
  logic [DST_W-1:0] result_nx;
  logic [IDX_W-1:0] dst_nx;
  logic             rsv_nx, off_nx;

  always_comb begin
    valid_nx  = q_valid;
    result_nx = q_result;
    dst_nx    = q_dst;
    rsv_nx    = q_rsv;
    off_nx    = q_off;
    if (load) begin
      valid_nx  = 1'b1;
      result_nx = d_result;
      dst_nx    = d_dst;
      rsv_nx    = d_rsv;
      off_nx    = d_off;
    end else if (drain) begin
      valid_nx  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_result <= '0;
      q_dst    <= '0;
      q_rsv    <= 1'b0;
      q_off    <= 1'b0;
    end else begin
      q_valid  <= valid_nx;
      q_result <= result_nx;
      q_dst    <= dst_nx;
      q_rsv    <= rsv_nx;
      q_off    <= off_nx;
    end
  end

  // R8: a stalled entry holds
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && !drain && !load |=> q_valid && $stable(q_result) && $stable(q_dst)
      && $stable(q_rsv) && $stable(q_off));
  // R8: an accepted word is visible after the edge
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q_valid);
endmodule

// File: rtl/hadd_unit.sv
module hadd_unit
  import hadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_insn,
  input  logic              in_compact,
  input  logic              dsp_en,
  input  logic [WORD_W-1:0] src_a,
  input  logic [WORD_W-1:0] src_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DST_W-1:0]  out_result,
  output logic [IDX_W-1:0]  out_dst,
  output logic              out_reserved,
  output logic              out_dsp_off
);
  localparam int unsigned EXT_W = DST_W - WORD_W;

  dec_t              dec;
  logic [WORD_W-1:0] lanes_y;
  logic [DST_W-1:0]  packed_res;
  logic [DST_W-1:0]  res_gated;
  logic              rsv_d, off_d, load;

  hadd_decode u_dec (
    .insn    (in_insn),
    .compact (in_compact),
    .dec     (dec)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    hadd_lane #(.W(LANE_W)) u_lane (
      .a   (src_a[g*LANE_W +: LANE_W]),
      .b   (src_b[g*LANE_W +: LANE_W]),
      .rnd (dec.rnd),
      .y   (lanes_y[g*LANE_W +: LANE_W])
    );
  end

  always_comb begin
    packed_res = {{EXT_W{lanes_y[WORD_W-1]}}, lanes_y};
    rsv_d      = !dec.hit;
    off_d      = dec.hit && !dsp_en;
    res_gated  = (dec.hit && dsp_en) ? packed_res : '0;
    in_ready   = !out_valid || out_ready;
    load       = in_valid && in_ready;
  end

  hadd_outreg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .drain    (out_ready),
    .d_result (res_gated),
    .d_dst    (dec.dst),
    .d_rsv    (rsv_d),
    .d_off    (off_d),
    .q_valid  (out_valid),
    .q_result (out_result),
    .q_dst    (out_dst),
    .q_rsv    (out_reserved),
    .q_off    (out_dsp_off)
  );

  // R6/R7: the two flags never coexist
  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_reserved, out_dsp_off}));
  // R6: flagged entries carry no result
  p_flag_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_reserved || out_dsp_off) |-> out_result == '0);
  // R3: upper half mirrors the upper-lane sign
  p_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_result[DST_W-1:WORD_W] == {EXT_W{out_result[WORD_W-1]}});
endmodule

// File: tb/hadd_unit_tb.sv
module hadd_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_compact, dsp_en;
  logic [31:0] in_insn, src_a, src_b;
  logic        out_valid, out_ready;
  logic [63:0] out_result;
  logic [4:0]  out_dst;
  logic        out_reserved, out_dsp_off;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hadd_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_compact(in_compact), .dsp_en(dsp_en),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_dst(out_dst), .out_reserved(out_reserved),
    .out_dsp_off(out_dsp_off)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] lane_ref(input logic [15:0] a, input logic [15:0] b,
                                           input bit rnd);
    int s;
    s = int'($signed(a)) + int'($signed(b)) + (rnd ? 1 : 0);
    s = s >>> 1;
    return s[15:0];
  endfunction

  function automatic logic [63:0] pack_ref(input logic [31:0] a, input logic [31:0] b,
                                           input bit rnd);
    logic [15:0] hi, lo;
    hi = lane_ref(a[31:16], b[31:16], rnd);
    lo = lane_ref(a[15:0], b[15:0], rnd);
    return {{32{hi[15]}}, hi, lo};
  endfunction

  function automatic logic [31:0] std_word(input bit rnd, input logic [4:0] d);
    return {6'b011111, 5'd3, 5'd7, d, (rnd ? 5'b01010 : 5'b01000), 6'b011000};
  endfunction

  function automatic logic [31:0] cmp_word(input bit rnd, input logic [4:0] d);
    return {6'b000000, 5'd9, 5'd4, d, (rnd ? 11'b10001001101 : 11'b00001001101)};
  endfunction

  // Drive at negedge, accept at posedge, sample at the following negedge.
  task automatic issue(input logic [31:0] w, input bit cmp, input bit en,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_insn = w; in_compact = cmp; dsp_en = en;
    src_a = a; src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  logic [15:0] vals [12];

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_insn = '0; in_compact = 1'b0;
    dsp_en = 1'b1; src_a = '0; src_b = '0; out_ready = 1'b1;
    vals = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFE, 16'h7FFF, 16'h8000,
             16'h8001, 16'hFFFF, 16'hFFFE, 16'h1234, 16'hC3A5, 16'h4000};
    repeat (3) @(negedge clk);
    // R9: reset state
    check64("R9 out_valid after reset", {63'd0, out_valid}, 64'd0);
    check64("R9 in_ready after reset", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R5: sweep lane pairs, both variants, both layouts
    for (int i = 0; i < 12; i++) begin
      for (int j = 0; j < 12; j++) begin
        for (int m = 0; m < 4; m++) begin
          bit rnd, cmp;
          logic [31:0] a, b, w;
          logic [4:0] d;
          rnd = m[0]; cmp = m[1];
          d = 5'(i + j + m);
          a = {vals[i], vals[(j + 5) % 12]};
          b = {vals[j], vals[(i + 7) % 12]};
          w = cmp ? cmp_word(rnd, d) : std_word(rnd, d);
          issue(w, cmp, 1'b1, a, b);
          check64(rnd ? "R2 R3 round result" : "R1 R3 trunc result",
                  out_result, pack_ref(a, b, rnd));
          check64(cmp ? "R5 dst/flags" : "R4 dst/flags",
                  {56'd0, out_valid, out_reserved, out_dsp_off, out_dst},
                  {56'd0, 1'b1, 1'b0, 1'b0, d});
        end
      end
    end

    // R1 R2: named corner cases (lower lane), upper lane negative for R3
    issue(std_word(0, 5'd1), 0, 1, 32'h8000_7FFF, 32'h8000_7FFF);
    check64("R1 7FFF+7FFF/8000+8000 trunc", out_result, {32'hFFFF_FFFF, 32'h8000_7FFF});
    issue(std_word(1, 5'd1), 0, 1, 32'h8000_7FFF, 32'h8000_7FFF);
    check64("R2 7FFF+7FFF/8000+8000 round", out_result, {32'hFFFF_FFFF, 32'h8000_7FFF});
    issue(cmp_word(0, 5'd2), 1, 1, 32'h0001_FFFF, 32'h0000_0000);
    check64("R1 FFFF+0000 trunc", out_result, {32'h0, 32'h0000_FFFF});
    issue(cmp_word(1, 5'd2), 1, 1, 32'h0001_FFFF, 32'h0000_0000);
    check64("R2 FFFF+0000 round", out_result, {32'h0, 32'h0001_0000});

    // R5: cross-table words are reserved
    issue(std_word(0, 5'd5), 1, 1, 32'h1111_1111, 32'h1111_1111);
    check64("R5 std word in compact mode", {61'd0, out_reserved, out_dsp_off, 1'b0}, {61'd0, 3'b100});
    issue(cmp_word(1, 5'd5), 0, 1, 32'h1111_1111, 32'h1111_1111);
    check64("R5 compact word in std mode", {61'd0, out_reserved, out_dsp_off, 1'b0}, {61'd0, 3'b100});

    // R6: unrecognised words, including near misses
    issue({6'b011111, 5'd1, 5'd2, 5'd3, 5'b01001, 6'b011000}, 0, 1, 32'h7FFF_7FFF, 32'h1);
    check64("R6 bad variant result", out_result, 64'd0);
    check64("R6 bad variant flags", {59'd0, out_reserved, out_dsp_off, 3'd0}, {59'd0, 2'b10, 3'd0});
    issue({6'b011111, 5'd1, 5'd2, 5'd3, 5'b01000, 6'b011001}, 0, 0, 32'h7FFF_7FFF, 32'h1);
    check64("R6 bad func, dsp off", {58'd0, out_reserved, out_dsp_off, out_dst, 1'b0}, {58'd0, 2'b10, 5'd0, 1'b0});
    issue({6'b000001, 5'd1, 5'd2, 5'd3, 11'b00001001101}, 1, 1, 32'h5, 32'h5);
    check64("R6 bad compact major", {62'd0, out_reserved, out_dsp_off}, {62'd0, 2'b10});
    check64("R6 bad compact major result", out_result, 64'd0);

    // R7: DSP disabled
    issue(std_word(1, 5'd17), 0, 0, 32'h4000_4000, 32'h4000_4000);
    check64("R7 std disabled result", out_result, 64'd0);
    check64("R7 std disabled flags", {62'd0, out_reserved, out_dsp_off}, {62'd0, 2'b01});
    issue(cmp_word(0, 5'd30), 1, 0, 32'h4000_4000, 32'h4000_4000);
    check64("R7 compact disabled flags", {62'd0, out_reserved, out_dsp_off}, {62'd0, 2'b01});

    // R8: stall holds the entry and blocks a second word
    @(negedge clk);
    out_ready = 1'b0;
    issue(std_word(0, 5'd12), 0, 1, 32'h0003_0005, 32'h0001_0001);
    check64("R8 stalled entry", out_result, 64'h0000_0000_0002_0003);
    check64("R8 in_ready low when stalled", {63'd0, in_ready}, 64'd0);
    in_valid = 1'b1; in_insn = std_word(1, 5'd13); src_a = 32'h7000_7000; src_b = 32'h7000_7000;
    repeat (3) @(negedge clk);
    check64("R8 held result", out_result, 64'h0000_0000_0002_0003);
    check64("R8 held dst/valid", {58'd0, out_valid, out_dst}, {58'd0, 1'b1, 5'd12});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check64("R8 second word after release", out_result, pack_ref(32'h7000_7000, 32'h7000_7000, 1));
    check64("R8 second dst", {59'd0, out_dst}, {59'd0, 5'd13});
    @(negedge clk);
    check64("R8 drained", {63'd0, out_valid}, 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule